// File: doc/BRIEF.md
# EDO DRAM Start-Up and Strobe Sequencer

This block drives the four active-low strobes of an asynchronous EDO DRAM (row strobe, column strobe, write enable, output enable) from a synchronous system clock. While the supply is coming up it holds the row and column strobes high. Once a power-good input has been high for a programmable number of clocks, it issues a train of row-only refresh cycles to warm up the array. Only after that does it raise its ready flag and start to accept requests. If no DRAM cycle is issued for longer than a programmable idle limit, it drops ready and runs the warm-up train again.

Each accepted request runs a fixed six-phase cycle, one phase per clock. There are four request kinds: read, early write, late (read-modify-write style) write, and column-before-row refresh. In a late write, output enable is raised at least one clock before write enable falls, so the DRAM releases the data pins in time for data setup.

The block also keeps a per-cycle model of whether the DRAM is driving its data pins. It enables the controller's own write-data drivers only when that model says the pins are released. Requests that arrive while the block is not ready, or is busy, are held off with a stall signal and are served later, never dropped.

Top module: `edo_init_seq`

## Requirements
- R1: Right after reset: ready=0, all four strobes are high, bus_drive_en=0 and dram_dq_on=0.
- R2: After pwr_ok rises, the row and column strobes stay high for PWR_WAIT_CYC clocks.
- R3: After the power wait, the block issues exactly WARM_CYC row-only cycles before ready rises. In each one the row strobe is low for five clocks while the column strobe, write enable and output enable stay high.
- R4: Request kinds are encoded as req_kind 0=read, 1=early write, 2=late write, 3=column-before-row refresh. A read, per phase 0..5, drives {ras_n,cas_n,we_n,oe_n} to 0111, 0011, 0010, 0010, 0010, 1111, with bus_drive_en=0 throughout.
- R5: An early write drives 0101, then 0001 for phases 1..4, then 1111. Write enable is low before the column strobe falls, and bus_drive_en=1 in phases 0..4.
- R6: A late write drives 0111, 0011, 0010, 0011, 0001, 1111. Output enable returns high one clock before write enable falls. bus_drive_en=1 only in phases 3 and 4.
- R7: A column-before-row refresh drives 1011, then 0011 for phases 1..3, then 0111, then 1111. bus_drive_en=0 throughout.
- R8: dram_dq_on reads 1 after a read and 0 after an early write, a late write or a row-only cycle. A column-before-row refresh leaves it unchanged. bus_drive_en is never 1 while dram_dq_on=1 or oe_n=0.
- R9: While ready=0 or a cycle is in progress, a valid request sees req_stall=1. It is accepted unchanged once the block can take it.
- R10: After IDLE_LIMIT_CYC clocks with no cycle issued, ready falls and a full warm-up train of WARM_CYC row-only cycles runs before ready rises again. Ready stays high for shorter idle gaps.
- R11: When pwr_ok falls, the next clock shows ready=0 and all strobes high. The power wait then restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_ok | input | 1 | Supply valid indication |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | Request kind: 0 read, 1 early write, 2 late write, 3 column-before-row refresh |
| req_stall | output | 1 | Request held off this clock |
| ready | output | 1 | Start-up complete, requests may be served |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| bus_drive_en | output | 1 | Enables the controller's write-data drivers |
| dram_dq_on | output | 1 | Model state: DRAM currently driving its data pins |

## Verification
The bench builds the block with PWR_WAIT_CYC=20, WARM_CYC=8 and IDLE_LIMIT_CYC=60, in place of wait and idle limits that would take tens of thousands of clocks. These values bring the full start-up, the idle-triggered warm-up rerun and a power-loss restart within a few hundred clocks, so each can be observed from beginning to end. The warm-up count keeps its real value of eight, so the bench counts row strobe falls against the number the DRAM actually needs.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [2:0] {
    K_READ = 3'd0,
    K_EWR  = 3'd1,
    K_LWR  = 3'd2,
    K_CBR  = 3'd3,
    K_ROR  = 3'd4
  } cyc_kind_e;

  typedef enum logic [1:0] {
    ST_PWR  = 2'd0,
    ST_WARM = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic oe_n;
  } strobe_t;

  localparam int PH_W    = 3;
  localparam int PH_LAST = 5;

  localparam strobe_t STROBE_IDLE = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};

  // Strobe levels for a given cycle kind and phase; the last phase is precharge.
  function automatic strobe_t strobe_fn(cyc_kind_e k, logic [PH_W-1:0] ph);
    strobe_t s;
    s = STROBE_IDLE;
    if (ph < PH_W'(PH_LAST)) begin
      case (k)
        K_READ: begin
          s.ras_n = 1'b0;
          s.cas_n = (ph == 3'd0);
          s.oe_n  = (ph < 3'd2);
        end
        K_EWR: begin
          s.ras_n = 1'b0;
          s.we_n  = 1'b0;
          s.cas_n = (ph == 3'd0);
        end
        K_LWR: begin
          s.ras_n = 1'b0;
          s.cas_n = (ph == 3'd0);
          s.oe_n  = (ph != 3'd2);
          s.we_n  = (ph != 3'd4);
        end
        K_CBR: begin
          s.cas_n = (ph == 3'd4);
          s.ras_n = (ph == 3'd0);
        end
        default: s.ras_n = 1'b0;
      endcase
    end
    return s;
  endfunction

  // Model of DRAM data-pin drive during a cycle.
  function automatic logic dq_fn(cyc_kind_e k, logic [PH_W-1:0] ph, logic prev);
    case (k)
      K_READ:  return 1'b1;
      K_LWR:   return (ph < 3'd3);
      K_CBR:   return prev;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic is_write(cyc_kind_e k);
    return (k == K_EWR) || (k == K_LWR);
  endfunction

endpackage

// File: rtl/edo_tick_counter.sv
module edo_tick_counter #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic en,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign hit = en && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt <= '0;
    else if (hit)        cnt <= '0;
    else if (en)         cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/edo_cycle_engine.sv
module edo_cycle_engine
  import edo_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      abort,
  input  logic      start,
  input  cyc_kind_e start_kind,
  output logic      busy,
  output logic      cyc_end,
  output strobe_t   strobes,
  output logic      dq_on,
  output logic      drive_en
);
  logic [PH_W-1:0] phase;
  cyc_kind_e       kind;
  logic            last_drv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      phase    <= '0;
      kind     <= K_ROR;
      last_drv <= 1'b0;
    end else begin
      if (busy) last_drv <= dq_on;
      if (abort) begin
        busy  <= 1'b0;
        phase <= '0;
      end else if (start && !busy) begin
        busy  <= 1'b1;
        phase <= '0;
        kind  <= start_kind;
      end else if (busy) begin
        if (cyc_end) busy <= 1'b0;
        else         phase <= phase + 1'b1;
      end
    end
  end

  assign cyc_end  = busy && (phase == PH_W'(PH_LAST));
  assign strobes  = busy ? strobe_fn(kind, phase) : STROBE_IDLE;
  assign dq_on    = busy ? dq_fn(kind, phase, last_drv) : last_drv;
  assign drive_en = busy && is_write(kind) && !dq_on && !cyc_end;
endmodule

// File: rtl/edo_init_seq.sv
module edo_init_seq
  import edo_pkg::*;
#(
  parameter int PWR_WAIT_CYC   = 10000,
  parameter int WARM_CYC       = 8,
  parameter int IDLE_LIMIT_CYC = 700000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_ok,
  input  logic       req_valid,
  input  logic [1:0] req_kind,
  output logic       req_stall,
  output logic       ready,
  output logic       ras_n,
  output logic       cas_n,
  output logic       we_n,
  output logic       oe_n,
  output logic       bus_drive_en,
  output logic       dram_dq_on
);
  localparam int WW = $clog2(WARM_CYC + 1);

  seq_state_e    state;
  logic [WW-1:0] warm_cnt;
  logic          busy, cyc_end, accept, warm_start, start;
  logic          pwr_hit, idle_hit, warm_done;
  logic          pwr_wait;
  logic [15:0]   warm_goal;
  cyc_kind_e     start_kind;
  strobe_t       strobes;

  assign pwr_wait   = (state == ST_PWR);
  assign warm_goal  = 16'(WARM_CYC);
  assign accept     = req_valid && (state == ST_RUN) && !busy && pwr_ok;
  assign warm_start = (state == ST_WARM) && !busy && pwr_ok;
  assign start      = accept || warm_start;
  assign start_kind = accept ? cyc_kind_e'({1'b0, req_kind}) : K_ROR;
  assign warm_done  = (state == ST_WARM) && cyc_end && (warm_cnt == WW'(WARM_CYC - 1));

  edo_tick_counter #(.LIMIT(PWR_WAIT_CYC)) u_pwr_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (!pwr_wait || !pwr_ok),
    .en    (pwr_wait && pwr_ok),
    .hit   (pwr_hit)
  );

  edo_tick_counter #(.LIMIT(IDLE_LIMIT_CYC)) u_idle_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear ((state != ST_RUN) || busy || accept),
    .en    ((state == ST_RUN) && !busy && !accept),
    .hit   (idle_hit)
  );

  edo_cycle_engine u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .abort      (!pwr_ok),
    .start      (start),
    .start_kind (start_kind),
    .busy       (busy),
    .cyc_end    (cyc_end),
    .strobes    (strobes),
    .dq_on      (dram_dq_on),
    .drive_en   (bus_drive_en)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_PWR;
      warm_cnt <= '0;
    end else if (!pwr_ok) begin
      state    <= ST_PWR;
      warm_cnt <= '0;
    end else begin
      case (state)
        ST_PWR: if (pwr_hit) state <= ST_WARM;
        ST_WARM: begin
          if (warm_done) begin
            state    <= ST_RUN;
            warm_cnt <= '0;
          end else if (cyc_end) begin
            warm_cnt <= warm_cnt + 1'b1;
          end
        end
        ST_RUN: if (idle_hit) begin
          state    <= ST_WARM;
          warm_cnt <= '0;
        end
        default: state <= ST_PWR;
      endcase
    end
  end

  assign ready     = (state == ST_RUN);
  assign req_stall = req_valid && !accept;
  assign ras_n     = strobes.ras_n;
  assign cas_n     = strobes.cas_n;
  assign we_n      = strobes.we_n;
  assign oe_n      = strobes.oe_n;
endmodule

// File: rtl/edo_init_seq_chk.sv
module edo_init_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pwr_ok,
  input logic        req_valid,
  input logic        req_stall,
  input logic        ready,
  input logic        ras_n,
  input logic        cas_n,
  input logic        we_n,
  input logic        oe_n,
  input logic        bus_drive_en,
  input logic        dram_dq_on,
  input logic        pwr_wait,
  input logic [15:0] warm_goal
);
  logic        ras_prev;
  logic [15:0] fall_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_prev <= 1'b1;
      fall_cnt <= '0;
    end else begin
      ras_prev <= ras_n;
      if (ready)                 fall_cnt <= '0;
      else if (ras_prev && !ras_n) fall_cnt <= fall_cnt + 1'b1;
    end
  end

  AST_PWR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_wait |-> (ras_n && cas_n)); // R2

  AST_WARM_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (fall_cnt >= warm_goal)); // R3

  AST_OE_BEFORE_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && $fell(we_n)) |-> $past(oe_n)); // R6

  AST_NO_CONTEND: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive_en |-> (oe_n && !dram_dq_on)); // R8

  AST_STALL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ready) |-> req_stall); // R9

  AST_PWR_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> (!ready && ras_n && cas_n)); // R11
endmodule

bind edo_init_seq edo_init_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pwr_ok       (pwr_ok),
  .req_valid    (req_valid),
  .req_stall    (req_stall),
  .ready        (ready),
  .ras_n        (ras_n),
  .cas_n        (cas_n),
  .we_n         (we_n),
  .oe_n         (oe_n),
  .bus_drive_en (bus_drive_en),
  .dram_dq_on   (dram_dq_on),
  .pwr_wait     (pwr_wait),
  .warm_goal    (warm_goal)
);

// File: tb/edo_init_seq_tb.sv
module edo_init_seq_tb;
  localparam int PWR_W = 20;
  localparam int WARM  = 8;
  localparam int IDLE  = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ok = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic req_stall, ready, ras_n, cas_n, we_n, oe_n, bus_drive_en, dram_dq_on;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  edo_init_seq #(.PWR_WAIT_CYC(PWR_W), .WARM_CYC(WARM), .IDLE_LIMIT_CYC(IDLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .req_valid(req_valid), .req_kind(req_kind),
    .req_stall(req_stall), .ready(ready), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .bus_drive_en(bus_drive_en), .dram_dq_on(dram_dq_on)
  );

  // Per phase {ras_n,cas_n,we_n,oe_n,bus_drive_en}, phase 0 in the low bits.
  localparam logic [29:0] PAT_RD  = {5'b11110, 5'b00100, 5'b00100, 5'b00100, 5'b00110, 5'b01110};
  localparam logic [29:0] PAT_EW  = {5'b11110, 5'b00011, 5'b00011, 5'b00011, 5'b00011, 5'b01011};
  localparam logic [29:0] PAT_LW  = {5'b11110, 5'b00011, 5'b00111, 5'b00100, 5'b00110, 5'b01110};
  localparam logic [29:0] PAT_CBR = {5'b11110, 5'b01110, 5'b00110, 5'b00110, 5'b00110, 5'b10110};

  // {dq_after, kind, pattern}
  localparam logic [32:0] TBL [6] = '{
    {1'b1, 2'd0, PAT_RD},
    {1'b1, 2'd3, PAT_CBR},
    {1'b0, 2'd1, PAT_EW},
    {1'b0, 2'd3, PAT_CBR},
    {1'b1, 2'd0, PAT_RD},
    {1'b0, 2'd2, PAT_LW}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic string kind_req(input logic [1:0] k);
    case (k)
      2'd0: return "R4";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Waits for ready, counting row strobe falls and checking warm cycle shape (R3, R9).
  task automatic wait_ready(output int falls);
    logic prev;
    int guard;
    falls = 0;
    prev = ras_n;
    guard = 0;
    while (!ready && guard < 3000) begin
      @(negedge clk);
      guard++;
      if (prev && !ras_n) falls++;
      prev = ras_n;
      if (!ras_n && !(cas_n && we_n && oe_n))
        check(1'b0, "R3", {28'd0, ras_n, cas_n, we_n, oe_n}, 4'b0111);
      if (req_valid && !ready && !req_stall)
        check(1'b0, "R9", 0, 1);
    end
    check(ready, "R3", ready, 1);
  endtask

  task automatic run_req(input logic [1:0] k, input logic [29:0] pat, input string req);
    int guard;
    guard = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_kind = k;
    #1;
    while (req_stall && guard < 3000) begin
      @(negedge clk);
      #1;
      guard++;
    end
    @(negedge clk);
    req_valid = 1'b0;
    for (int p = 0; p < 6; p++) begin
      check({ras_n, cas_n, we_n, oe_n, bus_drive_en} == pat[p*5 +: 5], req,
            {ras_n, cas_n, we_n, oe_n, bus_drive_en}, pat[p*5 +: 5]);
      if (p < 5) @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int falls;
    bit quiet;
    bit dropped;
    repeat (3) @(negedge clk);
    // R1: reset state
    check({ready, ras_n, cas_n, we_n, oe_n, bus_drive_en, dram_dq_on} == 7'b0111100, "R1",
          {ready, ras_n, cas_n, we_n, oe_n, bus_drive_en, dram_dq_on}, 7'b0111100);
    rst_n = 1'b1;
    pwr_ok = 1'b1;
    req_valid = 1'b1;   // R9: held from power-up, must be stalled
    req_kind = 2'd0;
    quiet = 1'b1;
    for (int i = 0; i < PWR_W; i++) begin
      @(negedge clk);
      if (!ras_n || !cas_n) quiet = 1'b0;
      if (!req_stall) quiet = 1'b0;
    end
    check(quiet, "R2", quiet, 1);
    wait_ready(falls);
    check(falls == WARM, "R3", falls, WARM);
    check(dram_dq_on == 1'b0, "R8", dram_dq_on, 0);
    // R9: the held read is served unchanged
    run_req(2'd0, PAT_RD, "R9");

    for (int i = 0; i < 6; i++) begin
      run_req(TBL[i][31:30], TBL[i][29:0], kind_req(TBL[i][31:30]));
      @(negedge clk);
      check(dram_dq_on == TBL[i][32], "R8", dram_dq_on, TBL[i][32]);
    end

    // R10: short idle keeps ready, long idle reruns warm-up
    repeat (IDLE - 10) @(negedge clk);
    check(ready == 1'b1, "R10", ready, 1);
    dropped = 1'b0;
    for (int i = 0; i < 30 && !dropped; i++) begin
      @(negedge clk);
      if (!ready) dropped = 1'b1;
    end
    check(dropped, "R10", dropped, 1);
    req_valid = 1'b1;
    req_kind = 2'd1;
    wait_ready(falls);
    check(falls == WARM, "R10", falls, WARM);
    run_req(2'd1, PAT_EW, "R9");

    // R11: power loss mid-cycle
    @(negedge clk);
    req_valid = 1'b1;
    req_kind = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    pwr_ok = 1'b0;
    @(negedge clk);
    check({ready, ras_n, cas_n, we_n, oe_n} == 5'b01111, "R11",
          {ready, ras_n, cas_n, we_n, oe_n}, 5'b01111);
    pwr_ok = 1'b1;
    quiet = 1'b1;
    for (int i = 0; i < PWR_W; i++) begin
      @(negedge clk);
      if (!ras_n || !cas_n || ready) quiet = 1'b0;
    end
    check(quiet, "R11", quiet, 1);
    wait_ready(falls);
    check(falls == WARM, "R11", falls, WARM);
    run_req(2'd3, PAT_CBR, "R7");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule